// File: doc/BRIEF.md
# Seven-Segment Single-Segment Sweep Tester

This block is a diagnostic pattern generator for a row of seven-segment displays. Once it is enabled, it lights a single segment on a single display. It moves that lit position one display at a time from the leftmost display to the rightmost. It then moves on to the next segment and repeats the walk, and after the last segment it starts again with the first. A person watching the row can therefore confirm every segment of every display, one at a time.

While the sweep runs, a separate indicator LED blinks at about one hertz. The blink shows that the self-test stage before this one finished cleanly. The step rate and the blink come from one prescaler tied to the clock frequency. For simulation, a shorter rate is chosen through parameters.

The block leaves the sweep when either of two push-buttons is pressed. On that press it emits a one-cycle exit pulse, turns all of its outputs dark, and stays out of the sweep until reset. Dropping the enable input pauses the sweep: the outputs go dark and the position returns to the start.

Top module: `seg_sweep_tester`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the cycle after it is released with the enable input low, the segment bus, the digit-select bus, the indicator and the exit pulse are all 0.
- R2: The sweep starts on the clock edge that samples the enable input high. From that edge onward, segment bit 0 (segment a) and digit bit 0 (the leftmost display) are lit, and the indicator is on.
- R3: While the sweep runs, the segment bus has exactly one bit set and the digit-select bus has exactly one bit set. Both buses are active-high.
- R4: Each position is held for exactly CLK_HZ/STEP_HZ clock cycles. The lit digit then moves from bit k to bit k+1, with bit 0 as the leftmost display, and the segment stays unchanged.
- R5: After the rightmost digit, the next position is the leftmost digit on the next segment in the order a..g (bits 0..6). After segment g (bit 6), the sweep returns to segment a.
- R6: The indicator changes state every STEP_HZ/2 steps. This gives a blink of about 1 Hz.
- R7: Both buttons are active-high and pass through a two-flop synchronizer. A rising edge on either button during the sweep takes effect on the third clock edge after the input rises. On that edge the exit pulse goes high for exactly one cycle, and on the same edge the segment, digit and indicator outputs go to 0.
- R8: A button that is pressed and released while the block is idle has no effect. A button that is already held high when the sweep starts does not end the sweep. Only a new rising edge does.
- R9: After the exit, the outputs stay at 0 and no further exit pulse occurs until reset, whatever the buttons and the enable input do.
- R10: When the enable input is sampled low during the sweep, all outputs are 0 from the next cycle. When the block is enabled again, the sweep restarts at segment a on the leftmost digit with the indicator on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enables the sweep while high |
| btn_a_i | input | 1 | First push-button, active-high, asynchronous |
| btn_b_i | input | 1 | Second push-button, active-high, asynchronous |
| seg_o | output | 7 | One-hot segment drive, bit 0 = a through bit 6 = g |
| dig_o | output | NUM_DIGITS | One-hot digit select, bit 0 = leftmost |
| hb_o | output | 1 | Heartbeat indicator |
| exit_o | output | 1 | One-cycle pulse when a button ends the sweep |

## Verification
The bench samples the sweep at chosen steps, including the last digit of one segment, the wrap from segment g back to a, and the indicator flips. A design that nested the two counters the wrong way round, or that skipped or repeated a step at a wrap, would show the wrong one-hot pair at one of those steps. The bench also checks the last cycle of a step against the first cycle of the next, which catches an off-by-one in the prescaler. It holds a button high across the start of the sweep and presses a button while idle. A level-sensitive exit would fire in both cases. After the exit it toggles the buttons and the enable input, to catch a mode that is not sticky or an exit pulse that fires more than once.

// File: rtl/seg_sweep_pkg.sv
// Package: shared constants and mode encoding for the sweep tester.
// Assumes: a standard seven-segment digit without a decimal point.
package seg_sweep_pkg;
    localparam int SEG_COUNT = 7;
    localparam int SEG_IW    = $clog2(SEG_COUNT);

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_SWEEP = 2'd1,
        MODE_DONE  = 2'd2
    } mode_t;
endpackage

// File: rtl/sweep_prescaler.sv
// Module: sweep_prescaler
// Emits a one-cycle tick every DIV cycles while run is high. The count
// restarts from zero whenever run is low, so the first tick after run rises
// arrives exactly DIV cycles later.
// Assumes: DIV >= 2.
module sweep_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles in the current step; clear when idle or at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick marks the final cycle of a step.
    always_comb begin
        tick = run && (cnt_q == LAST);
    end
endmodule

// File: rtl/sweep_button_sync.sv
// Module: sweep_button_sync
// Synchronizes NUM_BTN asynchronous active-high buttons with two flops each
// and flags a rising edge on any of them with a one-cycle press pulse.
// Assumes: presses are longer than a few clock cycles; no debouncing here.
module sweep_button_sync #(
    parameter int NUM_BTN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn_i,
    output logic               press_o
);
    logic [NUM_BTN-1:0] rise;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        logic meta_q, sync_q, prev_q;

        // Two-flop synchronizer plus a delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= btn_i[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Rising edge of the synchronized level.
        always_comb begin
            rise[i] = sync_q && !prev_q;
        end
    end

    // Any button edge counts as a press.
    always_comb begin
        press_o = |rise;
    end
endmodule

// File: rtl/sweep_position.sv
// Module: sweep_position
// Holds the sweep position: the digit index is the inner loop and the
// segment index is the outer loop. Also holds the heartbeat state, which
// toggles every HB_STEPS ticks. Everything returns to the start while run
// is low, with the heartbeat on.
// Assumes: tick is only high while run is high.
module sweep_position #(
    parameter int NUM_DIGITS = 4,
    parameter int HB_STEPS   = 4,
    parameter int DW         = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               run,
    input  logic                               tick,
    output logic [DW-1:0]                      dig_idx,
    output logic [seg_sweep_pkg::SEG_IW-1:0]   seg_idx,
    output logic                               hb
);
    import seg_sweep_pkg::*;

    localparam int HW = (HB_STEPS > 1) ? $clog2(HB_STEPS) : 1;
    localparam logic [DW-1:0]     DIG_LAST = DW'(NUM_DIGITS - 1);
    localparam logic [SEG_IW-1:0] SEG_LAST = SEG_IW'(SEG_COUNT - 1);
    localparam logic [HW-1:0]     HB_LAST  = HW'(HB_STEPS - 1);

    logic [DW-1:0]     dig_q;
    logic [SEG_IW-1:0] seg_q;
    logic [HW-1:0]     hb_cnt_q;
    logic              hb_q;

    // Advance the digit on each tick; step the segment when the digit wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dig_q <= '0;
            seg_q <= '0;
        end else if (tick) begin
            if (dig_q == DIG_LAST) begin
                dig_q <= '0;
                seg_q <= (seg_q == SEG_LAST) ? '0 : seg_q + 1'b1;
            end else begin
                dig_q <= dig_q + 1'b1;
            end
        end
    end

    // Count steps and flip the heartbeat every HB_STEPS of them.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hb_cnt_q <= '0;
            hb_q     <= 1'b1;
        end else if (tick) begin
            if (hb_cnt_q == HB_LAST) begin
                hb_cnt_q <= '0;
                hb_q     <= !hb_q;
            end else begin
                hb_cnt_q <= hb_cnt_q + 1'b1;
            end
        end
    end

    // Expose the registered state.
    always_comb begin
        dig_idx = dig_q;
        seg_idx = seg_q;
        hb      = hb_q;
    end
endmodule

// File: rtl/sweep_onehot.sv
// Module: sweep_onehot
// Gated binary-to-one-hot decoder: output bit i is high when en is high
// and idx equals i.
// Assumes: idx is below WIDTH when en is high.
module sweep_onehot #(
    parameter int WIDTH = 4,
    parameter int IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [IW-1:0]    idx,
    input  logic             en,
    output logic [WIDTH-1:0] out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One comparator per output line.
        always_comb begin
            out[i] = en && (idx == IW'(i));
        end
    end
endmodule

// File: rtl/seg_sweep_tester.sv
// Module: seg_sweep_tester (top)
// Mode control for the single-segment sweep. The mode goes from idle to
// sweep when enabled, and from sweep to done on a button edge. Done is
// left only by reset. Outputs are dark outside the sweep mode.
// Assumes: CLK_HZ is a multiple of STEP_HZ, STEP_HZ is even, and
// CLK_HZ/STEP_HZ >= 2.
module seg_sweep_tester #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int STEP_HZ    = 8,
    parameter int NUM_DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  btn_a_i,
    input  logic                  btn_b_i,
    output logic [6:0]            seg_o,
    output logic [NUM_DIGITS-1:0] dig_o,
    output logic                  hb_o,
    output logic                  exit_o
);
    import seg_sweep_pkg::*;

    localparam int DIV      = CLK_HZ / STEP_HZ;
    localparam int HB_STEPS = (STEP_HZ >= 2) ? STEP_HZ / 2 : 1;
    localparam int DW       = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    mode_t             mode_q, mode_d;
    logic              run, tick, press, exit_q, hb;
    logic [DW-1:0]     dig_idx;
    logic [SEG_IW-1:0] seg_idx;

    sweep_button_sync #(.NUM_BTN(2)) u_btn (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_i  ({btn_b_i, btn_a_i}),
        .press_o(press)
    );

    sweep_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    sweep_position #(.NUM_DIGITS(NUM_DIGITS), .HB_STEPS(HB_STEPS), .DW(DW)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .dig_idx(dig_idx),
        .seg_idx(seg_idx),
        .hb     (hb)
    );

    sweep_onehot #(.WIDTH(SEG_COUNT), .IW(SEG_IW)) u_seg_dec (
        .idx(seg_idx),
        .en (run),
        .out(seg_o)
    );

    sweep_onehot #(.WIDTH(NUM_DIGITS), .IW(DW)) u_dig_dec (
        .idx(dig_idx),
        .en (run),
        .out(dig_o)
    );

    // Next mode: a button edge wins over the enable input while sweeping.
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_IDLE:  if (en_i) mode_d = MODE_SWEEP;
            MODE_SWEEP: begin
                if (press)      mode_d = MODE_DONE;
                else if (!en_i) mode_d = MODE_IDLE;
            end
            MODE_DONE:  mode_d = MODE_DONE;
            default:    mode_d = MODE_IDLE;
        endcase
    end

    // Mode register and the registered exit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
            exit_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            exit_q <= (mode_q == MODE_SWEEP) && press;
        end
    end

    // Output gating: the sweep runs only in the sweep mode.
    always_comb begin
        run    = (mode_q == MODE_SWEEP);
        hb_o   = run && hb;
        exit_o = exit_q;
    end
endmodule

// File: rtl/seg_sweep_tester_chk.sv
// Module: seg_sweep_tester_chk
// Port-level properties of the sweep tester, bound to every instance.
// Assumes: the top-level port names and the NUM_DIGITS parameter.
module seg_sweep_tester_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en_i,
    input logic [6:0]            seg_o,
    input logic [NUM_DIGITS-1:0] dig_o,
    input logic                  hb_o,
    input logic                  exit_o
);
    logic done_seen_q;

    // Remember that an exit has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) done_seen_q <= 1'b0;
        else        done_seen_q <= done_seen_q || exit_o;
    end

    function automatic logic [NUM_DIGITS-1:0] rot_dig(input logic [NUM_DIGITS-1:0] v);
        logic [NUM_DIGITS-1:0] r;
        for (int i = 0; i < NUM_DIGITS; i++) r[(i + 1) % NUM_DIGITS] = v[i];
        return r;
    endfunction

    function automatic logic [6:0] rot_seg(input logic [6:0] v);
        return {v[5:0], v[6]};
    endfunction

    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (seg_o == '0 && dig_o == '0 && !hb_o && !exit_o));

    p_one_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_o != '0 || dig_o != '0) |-> ($countones(seg_o) == 1 && $countones(dig_o) == 1));

    p_digit_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_o != '0 && $past(dig_o) != '0 && dig_o != $past(dig_o))
        |-> (dig_o == rot_dig($past(dig_o))));

    p_seg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_o != '0 && $past(dig_o) != '0 && !dig_o[0]) |-> (seg_o == $past(seg_o)));

    p_seg_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_o[0] && $past(dig_o) != '0 && !$past(dig_o[0]))
        |-> (seg_o == rot_seg($past(seg_o))));

    p_exit_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |-> (seg_o == '0 && dig_o == '0 && !hb_o));

    p_exit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |=> !exit_o);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen_q |-> (!exit_o && seg_o == '0 && dig_o == '0 && !hb_o));

    p_disable_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (seg_o == '0 && dig_o == '0 && !hb_o));
endmodule

bind seg_sweep_tester seg_sweep_tester_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .seg_o (seg_o),
    .dig_o (dig_o),
    .hb_o  (hb_o),
    .exit_o(exit_o)
);

// File: tb/seg_sweep_tester_test.sv
// Bench for seg_sweep_tester: a table of sweep steps walked by one loop,
// then directed tests for disable, held buttons, exit and stickiness.
// Assumes: a short prescaler (4 cycles per step, 4 steps per blink half).
module seg_sweep_tester_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 32;
    localparam int STEP_HZ    = 8;
    localparam int NDIG       = 4;
    localparam int DIV        = CLK_HZ / STEP_HZ;

    // Each entry: {step[7:0], seg[6:0], dig[3:0], hb}
    localparam int NVEC = 11;
    localparam logic [19:0] VEC [NVEC] = '{
        {8'd0,  7'b0000001, 4'b0001, 1'b1},
        {8'd1,  7'b0000001, 4'b0010, 1'b1},
        {8'd3,  7'b0000001, 4'b1000, 1'b1},
        {8'd4,  7'b0000010, 4'b0001, 1'b0},
        {8'd6,  7'b0000010, 4'b0100, 1'b0},
        {8'd9,  7'b0000100, 4'b0010, 1'b1},
        {8'd15, 7'b0001000, 4'b1000, 1'b0},
        {8'd24, 7'b1000000, 4'b0001, 1'b1},
        {8'd27, 7'b1000000, 4'b1000, 1'b1},
        {8'd28, 7'b0000001, 4'b0001, 1'b0},
        {8'd29, 7'b0000001, 4'b0010, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n, en, btn_a, btn_b;
    logic [6:0]      seg;
    logic [NDIG-1:0] dig;
    logic            hb, ex;
    int              checks = 0;
    int              errors = 0;
    int              exit_count = 0;
    bit              finished = 1'b0;

    seg_sweep_tester #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ), .NUM_DIGITS(NDIG)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .btn_a_i(btn_a),
        .btn_b_i(btn_b),
        .seg_o  (seg),
        .dig_o  (dig),
        .hb_o   (hb),
        .exit_o (ex)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Count exit pulses, sampled between edges.
    always @(negedge clk) if (ex === 1'b1) exit_count++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pack all visible outputs for compact comparisons.
    function automatic logic [31:0] outs();
        return {19'd0, seg, dig, hb, ex};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int elapsed;
        int base;
        rst_n = 1'b0; en = 1'b0; btn_a = 1'b0; btn_b = 1'b0;
        cyc(3);
        chk("R1 outputs in reset", outs(), 32'd0);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 idle after reset", outs(), 32'd0);

        // R8: a press and release while idle must not matter.
        btn_a = 1'b1; cyc(5); btn_a = 1'b0; cyc(4);
        chk("R8 idle press no exit", exit_count, 0);

        // R2: start of sweep.
        en = 1'b1;
        cyc(1);
        elapsed = 0;
        chk("R2 first position", outs(), {19'd0, 7'b0000001, 4'b0001, 1'b1, 1'b0});

        // Table walk: R3/R4/R5/R6 at selected steps, one cycle into each.
        for (int i = 0; i < NVEC; i++) begin
            int target;
            target = int'(VEC[i][19:12]) * DIV + 1;
            cyc(target - elapsed);
            elapsed = target;
            chk($sformatf("R5 seg step %0d", VEC[i][19:12]), seg, VEC[i][11:5]);
            chk($sformatf("R4 dig step %0d", VEC[i][19:12]), dig, VEC[i][4:1]);
            chk($sformatf("R6 hb step %0d", VEC[i][19:12]), hb, VEC[i][0]);
            chk($sformatf("R3 one lit step %0d", VEC[i][19:12]),
                ($countones(seg) == 1 && $countones(dig) == 1), 1);
        end

        // R10: disable mid-sweep, then re-enable.
        en = 1'b0; cyc(1);
        chk("R10 disabled dark", outs(), 32'd0);
        en = 1'b1; cyc(1);
        chk("R10 restart position", outs(), {19'd0, 7'b0000001, 4'b0001, 1'b1, 1'b0});

        // R4: step boundary timing.
        cyc(DIV - 1);
        chk("R4 last cycle of step 0", dig, 4'b0001);
        cyc(1);
        chk("R4 first cycle of step 1", dig, 4'b0010);

        // R8: button held across the start of the sweep.
        en = 1'b0; cyc(1);
        btn_a = 1'b1; cyc(5);
        en = 1'b1; cyc(10);
        chk("R8 held button no exit", exit_count, 0);
        chk("R8 held button still sweeping", (seg != 0), 1);
        btn_a = 1'b0; cyc(5);
        chk("R8 release no exit", exit_count, 0);

        // R7: press the second button; exit on the third edge.
        btn_b = 1'b1;
        cyc(2);
        chk("R7 no exit before third edge", ex, 0);
        chk("R7 still sweeping before third edge", (dig != 0), 1);
        cyc(1);
        chk("R7 exit pulse and dark", outs(), 32'd1);
        cyc(1);
        chk("R7 exit one cycle wide", outs(), 32'd0);

        // R9: stickiness after exit.
        base = exit_count;
        btn_b = 1'b0; cyc(3);
        btn_a = 1'b1; cyc(5); btn_a = 1'b0;
        en = 1'b0; cyc(3); en = 1'b1; cyc(10);
        chk("R9 outputs stay dark", outs(), 32'd0);
        chk("R9 no further exit", exit_count, base);

        // R1: reset clears done; R7 via the first button.
        rst_n = 1'b0; cyc(2);
        chk("R1 reset from done", outs(), 32'd0);
        rst_n = 1'b1; cyc(1);
        chk("R2 sweep after reset", outs(), {19'd0, 7'b0000001, 4'b0001, 1'b1, 1'b0});
        btn_a = 1'b1;
        cyc(3);
        chk("R7 first button exit", outs(), 32'd1);
        btn_a = 1'b0;
        cyc(2);
        chk("R9 dark after first button exit", outs(), 32'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule